// File: doc/BRIEF.md
# Debug Suspend Signal Router

This block is a programmable crossbar that turns per-CPU debug-halt flags into per-peripheral suspend lines. Each of the output slots has its own 32-bit configuration word. The word names one CPU halt input by index and holds an enable bit. When a slot is enabled and points at a real CPU, its suspend output copies that CPU's halt flag, with one register stage of delay. A peripheral that should stop while a given core sits in debug halt is tied to a slot. Software then writes the core's index together with the enable bit into that slot's word.

Index 0 is reserved: it means "no CPU", and a slot that points at it never suspends. The configuration words are reached over a plain single-cycle memory-mapped bus. Slot N lives one word past its own number, so the word at offset zero and every address past the last slot are dead space. Whether the peripheral actually freezes is its own business. This block only drives the suspend line.

Top module: `dbg_suspend_xbar`

## Requirements
- R1: There are 128 slots, and slot N is configured through the 32-bit word at byte offset (N+1)*4. For example, slot 0 is at 0x004, slot 89 at 0x168 and slot 127 at 0x200.
- R2: Bits 4:0 of a slot word hold the CPU index and bit 16 holds the enable, so writing 0x10000 OR the index both selects the CPU and turns the route on.
- R3: All slot-word bits other than 4:0 and 16 read back as zero, and writes to them are ignored.
- R4: A slot whose index is 0, or whose enable is clear, holds its suspend output low whatever the halt inputs do.
- R5: An enabled slot with a nonzero index drives its suspend output from the halt input with that index, and from no other input.
- R6: A suspend output follows a change on its selected halt input after exactly one clock.
- R7: Reset clears every slot word to zero and deasserts every suspend output.
- R8: The word at offset 0x000, any offset above the last slot (0x204 and up) and any address with bits 1:0 nonzero all read as zero, and writes to them change nothing.
- R9: A write updates the slot word at the clock edge where it is presented, so a read in the next cycle returns the new fields and the suspend output reflects the new route one clock later.
- R10: Several slots may select the same CPU, and each of them follows that CPU's halt flag independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| halt_i | input | NUM_CPUS | Debug-halt flag of each CPU, bit k for index k |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_sel |
| susp_o | output | NUM_SLOTS | Suspend line of each peripheral slot |

## Verification
The bench builds the block with its defaults: 128 slots, 32 halt inputs and a 12-bit address. With these values the real edge offsets can be reached: 0x004 for the first slot, 0x200 for the last, 0x204 just beyond it, and 0x168 for a slot in the middle. Index 31 is also available, the top of the 5-bit field, so both ends of the index range and of the address map are covered with the sizes a real system uses.

// File: rtl/dbg_suspend_xbar.sv
module dbg_suspend_xbar #(
  parameter int NUM_SLOTS = 128,
  parameter int NUM_CPUS  = 32,
  parameter int ADDR_W    = 12,
  parameter int EN_BIT    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CPUS-1:0]  halt_i,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_SLOTS-1:0] susp_o
);
  localparam int IDX_W  = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1;
  localparam int PAD_N  = 1 << IDX_W;
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int WORD_W = ADDR_W - 2;

  logic [IDX_W-1:0]     cfg_idx [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] cfg_en;
  logic [NUM_SLOTS-1:0] susp_q;
  logic [PAD_N-1:0]     halt_pad;

  logic [WORD_W-1:0] word, word_m1;
  logic [SLOT_W-1:0] slot;
  logic              slot_hit, wr_hit;

  assign halt_pad = PAD_N'(halt_i);
  assign word     = bus_addr[ADDR_W-1:2];
  assign word_m1  = word - WORD_W'(1);
  assign slot     = word_m1[SLOT_W-1:0];
  assign slot_hit = (bus_addr[1:0] == 2'b00) && (word != '0) &&
                    (word <= WORD_W'(NUM_SLOTS));
  assign wr_hit   = bus_sel && bus_wr && slot_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SLOTS; s++) cfg_idx[s] <= '0;
      cfg_en <= '0;
    end else if (wr_hit) begin
      cfg_idx[slot] <= bus_wdata[IDX_W-1:0];
      cfg_en[slot]  <= bus_wdata[EN_BIT];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && slot_hit) begin
      bus_rdata[IDX_W-1:0] = cfg_idx[slot];
      bus_rdata[EN_BIT]    = cfg_en[slot];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) susp_q <= '0;
    else
      for (int s = 0; s < NUM_SLOTS; s++)
        susp_q[s] <= cfg_en[s] && (cfg_idx[s] != '0) && halt_pad[cfg_idx[s]];
  end

  assign susp_o = susp_q;

  localparam logic [31:0] RD_MASK = (32'(1) << EN_BIT) | 32'(PAD_N - 1);

  p_unused_bits_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~RD_MASK) == 32'd0);

  p_dead_space_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !slot_hit) |-> (bus_rdata == 32'd0));

  p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (cfg_idx[$past(slot)] == $past(bus_wdata[IDX_W-1:0])) &&
               (cfg_en[$past(slot)]  == $past(bus_wdata[EN_BIT])));

  p_reset_clears_r7: assert property (@(posedge clk)
    !rst_n |=> (susp_o == '0) && (cfg_en == '0));

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_quiet
    p_off_route_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en[g] || cfg_idx[g] == '0) |=> !susp_o[g]);
  end
endmodule

// File: tb/dbg_suspend_xbar_tb_top.sv
module dbg_suspend_xbar_tb_top;
  localparam int NS = 128;
  localparam int NC = 32;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] halt_i = '0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NS-1:0] susp_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dbg_suspend_xbar #(.NUM_SLOTS(NS), .NUM_CPUS(NC), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .susp_o(susp_o));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] slot_addr(input int s);
    return AW'((s + 1) * 4);
  endfunction

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  localparam int NV = 8;
  localparam int          V_SLOT [NV] = '{89, 89, 58, 77, 0, 127, 98, 3};
  localparam logic [31:0] V_WD   [NV] = '{32'h10011, 32'h00011, 32'h10000, 32'h10001,
                                          32'h10018, 32'h1001F, 32'h10009, 32'hFFFFFFE9};
  localparam logic [31:0] V_HALT [NV] = '{32'h00020000, 32'h00020000, 32'hFFFFFFFF, 32'h00000002,
                                          32'h00800000, 32'h80000000, 32'h00000200, 32'h00000200};
  localparam bit          V_EXP  [NV] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(susp_o == '0, "R7 outputs after reset", 32'(susp_o[31:0]), 0);
    bus_read(slot_addr(89), rd);
    chk(rd == 0, "R7 slot word after reset", rd, 0);

    for (int v = 0; v < NV; v++) begin
      halt_i = '0;
      bus_write(slot_addr(V_SLOT[v]), V_WD[v]);
      bus_read(slot_addr(V_SLOT[v]), rd);
      chk(rd == (V_WD[v] & 32'h1001F), $sformatf("R2 R3 readback vec %0d", v), rd, V_WD[v] & 32'h1001F);
      @(negedge clk); halt_i = V_HALT[v];
      @(negedge clk);
      chk(susp_o[V_SLOT[v]] == V_EXP[v], $sformatf("R4 R5 route vec %0d", v),
          32'(susp_o[V_SLOT[v]]), 32'(V_EXP[v]));
    end

    halt_i = '0;
    bus_write(slot_addr(89), 32'h10011);
    repeat (2) @(negedge clk);
    halt_i[17] = 1'b1;
    #1 chk(susp_o[89] == 1'b0, "R6 no change before edge", 32'(susp_o[89]), 0);
    @(negedge clk);
    chk(susp_o[89] == 1'b1, "R6 rise after one clock", 32'(susp_o[89]), 1);
    halt_i[17] = 1'b0;
    #1 chk(susp_o[89] == 1'b1, "R6 hold before edge", 32'(susp_o[89]), 1);
    @(negedge clk);
    chk(susp_o[89] == 1'b0, "R6 fall after one clock", 32'(susp_o[89]), 0);

    halt_i[17] = 1'b1;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = slot_addr(40); bus_wdata = 32'h10011;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    chk(susp_o[40] == 1'b0, "R9 output not yet routed", 32'(susp_o[40]), 0);
    bus_sel = 1'b1; bus_addr = slot_addr(40);
    #1 chk(bus_rdata == 32'h10011, "R9 read next cycle", bus_rdata, 32'h10011);
    @(negedge clk);
    bus_sel = 1'b0;
    chk(susp_o[40] == 1'b1, "R9 output one clock later", 32'(susp_o[40]), 1);
    halt_i = '0;

    bus_write(slot_addr(89), 32'h10011);
    bus_write(12'h000, 32'h10011);
    bus_write(12'h204, 32'h10011);
    bus_write(12'h169, 32'h00003);
    bus_write(12'h16A, 32'h00000);
    bus_read(12'h000, rd);
    chk(rd == 0, "R8 offset zero reads zero", rd, 0);
    bus_read(12'h204, rd);
    chk(rd == 0, "R8 past last slot reads zero", rd, 0);
    bus_read(12'h169, rd);
    chk(rd == 0, "R8 misaligned reads zero", rd, 0);
    bus_read(slot_addr(89), rd);
    chk(rd == 32'h10011, "R8 misaligned write ignored", rd, 32'h10011);
    bus_read(slot_addr(127), rd);
    chk(rd == 32'h1001F, "R8 last slot untouched", rd, 32'h1001F);
    bus_read(slot_addr(0), rd);
    chk(rd == 32'h10018, "R8 first slot untouched", rd, 32'h10018);

    bus_write(12'h004, 32'h10005);
    bus_write(12'h008, 32'h10006);
    halt_i = 32'h20;
    repeat (2) @(negedge clk);
    chk(susp_o[1:0] == 2'b01, "R1 slot 0 at 0x004, slot 1 at 0x008", 32'(susp_o[1:0]), 1);
    halt_i = 32'h40;
    repeat (2) @(negedge clk);
    chk(susp_o[1:0] == 2'b10, "R1 slot 1 follows its own word", 32'(susp_o[1:0]), 2);

    halt_i = '0;
    bus_write(slot_addr(10), 32'h10002);
    bus_write(slot_addr(20), 32'h10002);
    bus_write(slot_addr(30), 32'h10002);
    halt_i = 32'h4;
    repeat (2) @(negedge clk);
    chk({susp_o[30], susp_o[20], susp_o[10]} == 3'b111, "R10 shared CPU fan-out",
        32'({susp_o[30], susp_o[20], susp_o[10]}), 7);
    chk(susp_o[89] == 1'b0, "R5 other slot unaffected", 32'(susp_o[89]), 0);

    halt_i = '1;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(susp_o == '0, "R7 reset clears outputs", 32'(susp_o[31:0]), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(susp_o == '0, "R7 routes cleared by reset", 32'(susp_o[31:0]), 0);
    bus_read(slot_addr(10), rd);
    chk(rd == 0, "R7 slot word cleared", rd, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule